// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Flow-Through Reads

This block is a synthesizable behavioural model of a synchronous static memory meant to sit opposite a memory controller under verification. Every transfer starts on a rising clock edge where the load control is low. On that edge the memory takes the address, the direction, a chip-select and four active-low byte enables. Read data comes straight out of the array in the cycle that follows the edge, with no output register. Write data is taken one edge after its address. A read can therefore follow a write on the very next cycle, and the shared data bus never needs an idle turnaround cycle.

Write data sits in a one-entry buffer for one cycle and is committed to the array on the next enabled edge. A read that hits that buffer is served lane by lane from the buffer. Holding the load control high advances a two-bit burst counter over four words around the loaded address, in linear or interleaved order. A synchronous clock enable and a sleep input both freeze all state. An asynchronous output enable gates the read data.

Top module: `lw_sram`

## Requirements
- R1: On an enabled edge with `ld_n` low, a new cycle begins at `addr`. The cycle is a deselect when `cs_n` is high, a read when `cs_n` is low and `wr_n` is high, and a write when `cs_n` and `wr_n` are both low.
- R2: The data for a write cycle is sampled from `wdata` on the next enabled edge after the cycle's own edge, whatever cycle begins on that later edge. The array then holds the written bytes for every later read.
- R3: `be_n[i]` low enables byte lane i, which is bits 8i+7..8i of the data word. A write with all four enables high leaves the word unchanged.
- R4: A read registered on edge N presents its word on `rdata` with `rdata_oe` high between edge N and edge N+1.
- R5: `rdata_oe` is high only in a read cycle while `oe_n` is low, and it follows `oe_n` with no clock edge. `rdata` is zero whenever `rdata_oe` is low.
- R6: A read of the word whose write data is sampled on the same edge returns the new data in the enabled lanes and the stored bytes in the other lanes.
- R7: A deselect cycle produces no read data. A write issued just before a deselect still takes its data on the deselect's edge.
- R8: While `cen_n` is high, clock edges have no effect: the current cycle, the burst position and the pending write data all hold.
- R9: On an enabled edge with `ld_n` high, a read or write cycle steps its burst counter k by one, modulo 4. Word bits [1:0] are base+k (mod 4) when `burst_lin` was 1 at load, and base XOR k when it was 0. The upper address bits stay fixed, the cycle type is kept, and `be_n` is sampled again for each burst write.
- R10: While `sleep` is high, edges are ignored exactly as in R8 and `rdata_oe` is low. Once `sleep` falls, the held cycle drives its data again, and operation resumes on the next enabled edge.
- R11: After reset the block is deselected, with `rdata_oe` low and no pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Active-low synchronous clock enable |
| sleep | input | 1 | Freezes all state and turns off the read output |
| ld_n | input | 1 | Low: load a new cycle; high: advance the burst |
| cs_n | input | 1 | Active-low chip select, sampled at load |
| wr_n | input | 1 | High: read, low: write, sampled at load |
| burst_lin | input | 1 | Burst order sampled at load: 1 linear, 0 interleaved |
| be_n | input | 4 | Active-low byte enables, one per byte lane |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data, one edge after its address |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | 32 | Read data, zero while not enabled |
| rdata_oe | output | 1 | High while `rdata` is driven |

## Verification
The interesting collision is the commit of a late write landing on the same edge as a read of that word. At that moment the array still holds the old bytes and the new data exists only in the write buffer. The bench provokes this in two ways. One is a partial-lane write followed straight away by a read of the same word. The other is a burst of writes whose last data arrives on the edge that loads an interleaved read burst starting at that word. Each returned word is judged against a lane-by-lane merge worked out beforehand from the old and new bytes. The word is read again once the commit has happened, to confirm the merge was not only a forwarding artefact.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;

  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;

  typedef enum logic [1:0] {
    OP_DESEL = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Low two word bits at burst step k
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] step,
                                           input logic       linear);
    return linear ? 2'(base + step) : (base ^ step);
  endfunction

  // Take new bytes where take[i] is set, keep old bytes elsewhere
  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [WORD_W-1:0] new_w,
                                                   input logic [LANES-1:0]  take);
    logic [WORD_W-1:0] res;
    for (int i = 0; i < LANES; i++) begin
      res[i*BYTE_W +: BYTE_W] = take[i] ? new_w[i*BYTE_W +: BYTE_W]
                                        : old_w[i*BYTE_W +: BYTE_W];
    end
    return res;
  endfunction

endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                edge_en,
  input  logic                ld_n,
  input  logic                cs_n,
  input  logic                wr_n,
  input  logic                burst_lin,
  input  logic [LANES-1:0]    be_n,
  input  logic [AW-1:0]       addr,
  output op_e                 c_op,
  output logic [AW-1:0]       c_addr,
  output logic [LANES-1:0]    c_be_n,
  output logic [1:0]          c_step
);

  logic [AW-1:0] base_q;
  logic          lin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_op   <= OP_DESEL;
      base_q <= '0;
      lin_q  <= 1'b1;
      c_step <= 2'd0;
      c_be_n <= '1;
    end else if (edge_en) begin
      c_be_n <= be_n;
      if (!ld_n) begin
        c_op   <= cs_n ? OP_DESEL : (wr_n ? OP_READ : OP_WRITE);
        base_q <= addr;
        lin_q  <= burst_lin;
        c_step <= 2'd0;
      end else if (c_op != OP_DESEL) begin
        c_step <= c_step + 2'd1;
      end
    end
  end

  assign c_addr = {base_q[AW-1:2], burst_low(base_q[1:0], c_step, lin_q)};

endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf
  import lw_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                edge_en,
  input  op_e                 c_op,
  input  logic [AW-1:0]       c_addr,
  input  logic [LANES-1:0]    c_be_n,
  input  logic [WORD_W-1:0]   wdata,
  output logic                w_valid,
  output logic [AW-1:0]       w_addr,
  output logic [LANES-1:0]    w_be_n,
  output logic [WORD_W-1:0]   w_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_valid <= 1'b0;
      w_addr  <= '0;
      w_be_n  <= '1;
      w_data  <= '0;
    end else if (edge_en) begin
      w_valid <= (c_op == OP_WRITE);
      if (c_op == OP_WRITE) begin
        w_addr <= c_addr;
        w_be_n <= c_be_n;
        w_data <= wdata;
      end
    end
  end

endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array
  import lw_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                clk,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [LANES-1:0]    wbe_n,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [AW-1:0]       raddr,
  output logic [WORD_W-1:0]   rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && !wbe_n[g]) mem[waddr] <= wdata[g*BYTE_W +: BYTE_W];
    end

    assign rdata[g*BYTE_W +: BYTE_W] = mem[raddr];
  end

endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cen_n,
  input  logic                sleep,
  input  logic                ld_n,
  input  logic                cs_n,
  input  logic                wr_n,
  input  logic                burst_lin,
  input  logic [3:0]          be_n,
  input  logic [AW-1:0]       addr,
  input  logic [31:0]         wdata,
  input  logic                oe_n,
  output logic [31:0]         rdata,
  output logic                rdata_oe
);

  logic              edge_en;
  op_e               c_op;
  logic [AW-1:0]     c_addr;
  logic [LANES-1:0]  c_be_n;
  logic [1:0]        c_step;
  logic              w_valid;
  logic [AW-1:0]     w_addr;
  logic [LANES-1:0]  w_be_n;
  logic [WORD_W-1:0] w_data;
  logic [WORD_W-1:0] arr_q;
  logic              commit;
  logic              fwd_hit;
  logic [WORD_W-1:0] read_word;

  assign edge_en = !cen_n && !sleep;
  assign commit  = edge_en && w_valid;

  lw_sram_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .edge_en(edge_en), .ld_n(ld_n), .cs_n(cs_n),
    .wr_n(wr_n), .burst_lin(burst_lin), .be_n(be_n), .addr(addr),
    .c_op(c_op), .c_addr(c_addr), .c_be_n(c_be_n), .c_step(c_step)
  );

  lw_sram_wbuf #(.AW(AW)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .edge_en(edge_en), .c_op(c_op), .c_addr(c_addr),
    .c_be_n(c_be_n), .wdata(wdata), .w_valid(w_valid), .w_addr(w_addr),
    .w_be_n(w_be_n), .w_data(w_data)
  );

  lw_sram_array #(.AW(AW)) u_array (
    .clk(clk), .we(commit), .waddr(w_addr), .wbe_n(w_be_n), .wdata(w_data),
    .raddr(c_addr), .rdata(arr_q)
  );

  assign fwd_hit   = w_valid && (w_addr == c_addr);
  assign read_word = lane_merge(arr_q, w_data, ~w_be_n & {LANES{fwd_hit}});
  assign rdata_oe  = (c_op == OP_READ) && !oe_n && !sleep;
  assign rdata     = rdata_oe ? read_word : '0;

endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk
  import lw_sram_pkg::*;
#(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          edge_en,
  input logic          ld_n,
  input logic          oe_n,
  input logic          sleep,
  input op_e           c_op,
  input logic [AW-1:0] c_addr,
  input logic [1:0]    c_step,
  input logic          w_valid,
  input logic [AW-1:0] w_addr,
  input logic          rdata_oe
);

  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_en && !ld_n |=> c_step == 2'd0); // R1
  AST_LATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    edge_en && c_op == OP_WRITE |=> w_valid && w_addr == $past(c_addr)); // R2
  AST_NO_STRAY_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    edge_en && c_op != OP_WRITE |=> !w_valid); // R7
  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rdata_oe); // R5
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    c_op != OP_READ |-> !rdata_oe); // R7
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_en |=> $stable(c_op) && $stable(c_addr) && $stable(w_valid)); // R8
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    edge_en && ld_n && c_op != OP_DESEL |=> c_step == 2'($past(c_step) + 2'd1)); // R9
  AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !rdata_oe); // R10

endmodule

bind lw_sram lw_sram_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .edge_en(edge_en), .ld_n(ld_n), .oe_n(oe_n),
  .sleep(sleep), .c_op(c_op), .c_addr(c_addr), .c_step(c_step),
  .w_valid(w_valid), .w_addr(w_addr), .rdata_oe(rdata_oe)
);

// File: tb/lw_sram_bench.sv
`timescale 1ns/1ps
module lw_sram_bench;

  localparam int AW = 6;
  localparam int NV = 13;

  logic clk = 1'b0;
  logic rst_n, cen_n, sleep, ld_n, cs_n, wr_n, burst_lin, oe_n;
  logic [3:0]    be_n;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;
  logic          rdata_oe;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lw_sram #(.AW(AW)) u_lw_sram (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sleep(sleep), .ld_n(ld_n),
    .cs_n(cs_n), .wr_n(wr_n), .burst_lin(burst_lin), .be_n(be_n), .addr(addr),
    .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  // {ld_n, cs_n, wr_n, be_n, addr, wdata, exp_oe, exp_data}
  localparam logic [77:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 4'b0000, 6'd5, 32'h0,         1'b0, 32'h0},         // write 5
    {1'b0, 1'b0, 1'b0, 4'b0000, 6'd6, 32'h11223344,  1'b0, 32'h0},         // write 6, data 5
    {1'b0, 1'b0, 1'b1, 4'b0000, 6'd5, 32'h55667788,  1'b1, 32'h11223344},  // read 5, data 6
    {1'b0, 1'b0, 1'b1, 4'b0000, 6'd6, 32'h0,         1'b1, 32'h55667788},  // read 6
    {1'b0, 1'b0, 1'b0, 4'b1010, 6'd5, 32'h0,         1'b0, 32'h0},         // lanes 0,2 of 5
    {1'b0, 1'b0, 1'b1, 4'b0000, 6'd5, 32'hAABBCCDD,  1'b1, 32'h11BB33DD},  // forwarded merge
    {1'b0, 1'b0, 1'b1, 4'b0000, 6'd5, 32'h0,         1'b1, 32'h11BB33DD},  // after commit
    {1'b0, 1'b0, 1'b0, 4'b1111, 6'd6, 32'h0,         1'b0, 32'h0},         // no-lane write
    {1'b0, 1'b1, 1'b0, 4'b0000, 6'd0, 32'hFFFFFFFF,  1'b0, 32'h0},         // deselect
    {1'b0, 1'b0, 1'b1, 4'b0000, 6'd6, 32'h0,         1'b1, 32'h55667788},  // unchanged
    {1'b0, 1'b0, 1'b0, 4'b0000, 6'd8, 32'h0,         1'b0, 32'h0},         // write 8
    {1'b0, 1'b1, 1'b1, 4'b0000, 6'd0, 32'hCAFEF00D,  1'b0, 32'h0},         // deselect, data 8
    {1'b0, 1'b0, 1'b1, 4'b0000, 6'd8, 32'h0,         1'b1, 32'hCAFEF00D}   // read 8
  };

  task automatic check(input string tag, input logic exp_oe, input logic [31:0] exp_d);
    checks++;
    if (rdata_oe !== exp_oe || rdata !== exp_d) begin
      errs++;
      $display("FAIL %s: got oe=%b data=%h, expected oe=%b data=%h",
               tag, rdata_oe, rdata, exp_oe, exp_d);
    end
  endtask

  task automatic drive(input logic l, input logic c, input logic w, input logic [3:0] b,
                       input logic [AW-1:0] a, input logic [31:0] d);
    ld_n = l; cs_n = c; wr_n = w; be_n = b; addr = a; wdata = d;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: got hung run, expected completion");
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; cen_n = 1'b0; sleep = 1'b0; oe_n = 1'b0; burst_lin = 1'b1;
    drive(1'b0, 1'b1, 1'b1, 4'hF, '0, '0);
    repeat (3) tick();
    rst_n = 1'b1;
    check("R11 reset", 1'b0, 32'h0);
    tick();
    check("R11 idle after reset", 1'b0, 32'h0);

    // Vector table: R1 R2 R3 R4 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [77:0] v;
      v = VEC[i];
      drive(v[77], v[76], v[75], v[74:71], v[70:65], v[64:33]);
      tick();
      check($sformatf("R1/R2/R3/R4/R6/R7 row %0d", i), v[32], v[31:0]);
    end

    // R9: linear write burst from 0x12, then interleaved read burst from 0x11
    burst_lin = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 4'h0, 6'h12, 32'h0);        tick();
    drive(1'b1, 1'b0, 1'b0, 4'h0, 6'h0, 32'hD0D0_0000); tick(); // 0x12
    drive(1'b1, 1'b0, 1'b0, 4'h0, 6'h0, 32'hD1D1_0001); tick(); // 0x13
    drive(1'b1, 1'b0, 1'b0, 4'h0, 6'h0, 32'hD2D2_0002); tick(); // 0x10
    check("R9 write burst quiet", 1'b0, 32'h0);
    burst_lin = 1'b0;
    drive(1'b0, 1'b0, 1'b1, 4'h0, 6'h11, 32'hD3D3_0003); tick(); // data 0x11
    check("R9/R6 burst read 0x11 forwarded", 1'b1, 32'hD3D3_0003);
    drive(1'b1, 1'b0, 1'b1, 4'h0, 6'h0, 32'h0); tick();
    check("R9 interleaved 0x10", 1'b1, 32'hD2D2_0002);
    tick();
    check("R9 interleaved 0x13", 1'b1, 32'hD1D1_0001);
    tick();
    check("R9 interleaved 0x12", 1'b1, 32'hD0D0_0000);
    tick();
    check("R9 wrap to 0x11", 1'b1, 32'hD3D3_0003);
    burst_lin = 1'b1;

    // R8: clock enable freezes cycle and pending write data
    drive(1'b0, 1'b0, 1'b0, 4'h0, 6'd9, 32'h0); tick();
    cen_n = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 4'h0, 6'd5, 32'hDEAD0000); tick();
    check("R8 frozen write cycle", 1'b0, 32'h0);
    cen_n = 1'b0;
    drive(1'b0, 1'b1, 1'b1, 4'h0, 6'd0, 32'h0000BEEF); tick();
    drive(1'b0, 1'b0, 1'b1, 4'h0, 6'd9, 32'h0); tick();
    check("R8 data taken on enabled edge", 1'b1, 32'h0000BEEF);

    // R5: asynchronous output enable
    drive(1'b0, 1'b0, 1'b1, 4'h0, 6'd5, 32'h0); tick();
    check("R5 read on", 1'b1, 32'h11BB33DD);
    oe_n = 1'b1; #1;
    check("R5 oe_n high turns off", 1'b0, 32'h0);
    oe_n = 1'b0; #1;
    check("R5 oe_n low turns on", 1'b1, 32'h11BB33DD);

    // R10: sleep freezes and silences
    sleep = 1'b1;
    drive(1'b0, 1'b0, 1'b1, 4'h0, 6'd6, 32'h0); tick();
    check("R10 sleep output off", 1'b0, 32'h0);
    sleep = 1'b0; #1;
    check("R10 held read returns", 1'b1, 32'h11BB33DD);
    tick();
    check("R10 resumed read", 1'b1, 32'h55667788);

    done = 1'b1;
    summary();
  end

endmodule